// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out fetch-and-op atomic memory operations for a 64-bit core, at both word (32-bit) and doubleword (64-bit) width. It takes a 32-bit R-type atomic instruction word, the effective address, and the source operand value. It decodes the operation, the width, the destination register and the two ordering bits. It then runs a locked read-then-write sequence over a simple single-beat memory port and hands the original memory value back for the register file.

The memory port uses a request/grant handshake, followed by a response strobe for each beat. The lock output rises with the read request and stays high until the write is acknowledged, so the interconnect can keep every other access out of the window. The two ordering bits are not enforced here. They are exported for the whole operation as acquire and release side-band signals for the load/store unit. A misaligned address is trapped before any memory traffic, unless the atomicity-granule input says the access fits inside one granule.

Top module: `amo_rmw_unit`

## Requirements
- R1: The instruction word is decoded as funct5 [31:27], aq [26], rl [25], width [14:12], rd [11:7], opcode [6:0]. Only opcode 0101111 with width 010 (word) or 011 (doubleword) and funct5 one of ADD 00000, SWAP 00001, XOR 00100, OR 01000, AND 01100, MIN 10000, MAX 10100, MINU 11000, MAXU 11100 is legal. Any other word completes with `op_illegal` high at `done`, with no memory request and no register write.
- R2: A legal, aligned operation issues exactly one read beat and then one write beat to the same address. `mem_lock` is high from the read request until the write response, and low once `done` is reached.
- R3: SWAP, ADD, AND, OR and XOR write back the source value, the sum, or the bitwise result of the old memory value and the source value. The sum wraps modulo the operation width.
- R4: MIN and MAX compare as two's-complement values, and MINU and MAXU compare as unsigned values, at the selected width. The selected value is written back.
- R5: For word operations, bits [63:32] of the source value are ignored. The word sits in bits [31:0] of `mem_rdata` and `mem_wdata`, and `mem_wdata[63:32]` is zero. `rd_data` is the old word sign-extended to 64 bits. `mem_dword` is 1 for doubleword and 0 for word.
- R6: At `done`, `rd_we` is high and `rd_data` carries the old memory value if and only if the operation was legal, not trapped, and rd is not 0. When rd is 0 the memory update still happens.
- R7: A word address with bits [1:0] nonzero, or a doubleword address with bits [2:0] nonzero, sets `misaligned` at `done` when `granule_ok` is low. No memory request is issued and no register write occurs in that case.
- R8: When `granule_ok` is high at acceptance, a misaligned access proceeds as a normal single locked operation with `misaligned` low.
- R9: `acquire` and `release_o` equal the accepted aq and rl bits for every cycle while `busy` is high, and are low while idle.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. A `req_valid` seen while busy is ignored and does not change the running operation.
- R11: After reset, `busy`, `done`, `mem_req`, `mem_lock`, `rd_we`, `acquire` and `release_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| instr | input | 32 | Atomic instruction word |
| addr | input | ADDR_W | Effective byte address |
| src_val | input | 64 | Source operand value |
| granule_ok | input | 1 | Access lies within one atomicity granule |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_dword | output | 1 | 1 = doubleword, 0 = word |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | 64 | Write data |
| mem_lock | output | 1 | Bus lock over the read-write window |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Beat response (read data or write acknowledge) |
| mem_rdata | input | 64 | Read data |
| acquire | output | 1 | Acquire ordering side-band |
| release_o | output | 1 | Release ordering side-band |
| done | output | 1 | One-cycle completion strobe |
| rd_we | output | 1 | Register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Old memory value, width-adjusted |
| misaligned | output | 1 | Misaligned exception, valid with done |
| op_illegal | output | 1 | Unsupported encoding, valid with done |

## Verification
The assertions check, on every cycle, the properties of the sequence itself. The lock is never missing during a beat and never drops before the write acknowledge. The ordering side-band stays stable while busy. A register write happens only at completion and never to x0. Trapped or illegal operations produce no memory request. Word writes carry a zero upper half. The arithmetic results are shown only by the bench: it sweeps all nine operations at both widths over signed and unsigned corner operands. The same holds for the sign extension of returned words, the preservation of the neighbouring word in memory, the granule override, and the ignored mid-operation request.

// File: rtl/amo_rmw_pkg.sv
package amo_rmw_pkg;

  typedef enum logic [3:0] {
    K_ADD, K_SWAP, K_XOR, K_OR, K_AND, K_MIN, K_MAX, K_MINU, K_MAXU
  } amo_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_DONE
  } amo_state_e;

  localparam logic [6:0] ATOMIC_OPCODE = 7'b0101111;
  localparam logic [2:0] WIDTH_WORD    = 3'b010;
  localparam logic [2:0] WIDTH_DWORD   = 3'b011;

  // Widen a value of the selected width to 64 bits, signed or unsigned.
  function automatic logic [63:0] widen(input logic word, input logic sgn,
                                        input logic [63:0] v);
    if (!word) return v;
    return sgn ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
  endfunction

  // New memory value; word results are returned in bits [31:0], upper zero.
  function automatic logic [63:0] combine(input amo_kind_e k, input logic word,
                                          input logic [63:0] old_v,
                                          input logic [63:0] src_v);
    logic [63:0] sa, sb, ua, ub, r;
    logic s_lt, u_lt;
    sa = widen(word, 1'b1, old_v);
    sb = widen(word, 1'b1, src_v);
    ua = widen(word, 1'b0, old_v);
    ub = widen(word, 1'b0, src_v);
    s_lt = $signed(sa) < $signed(sb);
    u_lt = ua < ub;
    case (k)
      K_ADD:  r = sa + sb;
      K_SWAP: r = sb;
      K_XOR:  r = sa ^ sb;
      K_OR:   r = sa | sb;
      K_AND:  r = sa & sb;
      K_MIN:  r = s_lt ? sa : sb;
      K_MAX:  r = s_lt ? sb : sa;
      K_MINU: r = u_lt ? ua : ub;
      K_MAXU: r = u_lt ? ub : ua;
      default: r = sb;
    endcase
    return word ? {32'b0, r[31:0]} : r;
  endfunction

endpackage

// File: rtl/amo_rmw_decode.sv
module amo_rmw_decode
  import amo_rmw_pkg::*;
(
  input  logic [31:0] instr,
  output amo_kind_e   kind,
  output logic        is_word,
  output logic [4:0]  rd,
  output logic        aq,
  output logic        rl,
  output logic        legal
);
  logic [4:0] f5;
  logic [2:0] wfield;
  logic       f5_ok;

  assign f5     = instr[31:27];
  assign aq     = instr[26];
  assign rl     = instr[25];
  assign wfield = instr[14:12];
  assign rd     = instr[11:7];

  always_comb begin
    f5_ok = 1'b1;
    kind  = K_ADD;
    case (f5)
      5'b00000: kind = K_ADD;
      5'b00001: kind = K_SWAP;
      5'b00100: kind = K_XOR;
      5'b01000: kind = K_OR;
      5'b01100: kind = K_AND;
      5'b10000: kind = K_MIN;
      5'b10100: kind = K_MAX;
      5'b11000: kind = K_MINU;
      5'b11100: kind = K_MAXU;
      default:  f5_ok = 1'b0;
    endcase
  end

  assign is_word = (wfield == WIDTH_WORD);
  assign legal   = f5_ok && (instr[6:0] == ATOMIC_OPCODE) &&
                   ((wfield == WIDTH_WORD) || (wfield == WIDTH_DWORD));
endmodule

// File: rtl/amo_rmw_alu.sv
module amo_rmw_alu
  import amo_rmw_pkg::*;
(
  input  amo_kind_e   kind,
  input  logic        is_word,
  input  logic [63:0] old_val,
  input  logic [63:0] src_val,
  output logic [63:0] new_val,
  output logic [63:0] ret_val
);
  assign new_val = combine(kind, is_word, old_val, src_val);
  assign ret_val = widen(is_word, 1'b1, old_val);
endmodule

// File: rtl/amo_rmw_ctrl.sv
module amo_rmw_ctrl
  import amo_rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  amo_kind_e         dec_kind,
  input  logic              dec_word,
  input  logic [4:0]        dec_rd,
  input  logic              dec_aq,
  input  logic              dec_rl,
  input  logic              dec_legal,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       src_val,
  input  logic              granule_ok,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  input  logic [63:0]       new_val,
  input  logic [63:0]       ret_val,
  output amo_kind_e         cap_kind,
  output logic              cap_word,
  output logic [63:0]       cap_src,
  output logic [63:0]       cap_old,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              mem_lock,
  output logic              acquire,
  output logic              release_o,
  output logic              done,
  output logic              rd_we,
  output logic [4:0]        rd_idx,
  output logic [63:0]       rd_data,
  output logic              misaligned,
  output logic              op_illegal
);
  amo_state_e        state;
  logic [ADDR_W-1:0] cap_addr;
  logic [4:0]        cap_rd;
  logic              cap_aq, cap_rl, cap_mis, cap_ill;

  // Named events for the checks
  logic accept_evt, trap_evt, rd_beat_evt, wr_ack_evt, mis_raw;

  assign mis_raw     = dec_word ? (addr[1:0] != 2'b00) : (addr[2:0] != 3'b000);
  assign accept_evt  = (state == S_IDLE) && req_valid;
  assign trap_evt    = accept_evt && (!dec_legal || (mis_raw && !granule_ok));
  assign rd_beat_evt = (state == S_RD_WAIT) && mem_rvalid;
  assign wr_ack_evt  = (state == S_WR_WAIT) && mem_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cap_kind <= K_ADD;
      cap_word <= 1'b0;
      cap_src  <= '0;
      cap_old  <= '0;
      cap_addr <= '0;
      cap_rd   <= '0;
      cap_aq   <= 1'b0;
      cap_rl   <= 1'b0;
      cap_mis  <= 1'b0;
      cap_ill  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cap_kind <= dec_kind;
          cap_word <= dec_word;
          cap_src  <= src_val;
          cap_addr <= addr;
          cap_rd   <= dec_rd;
          cap_aq   <= dec_aq;
          cap_rl   <= dec_rl;
          cap_ill  <= !dec_legal;
          cap_mis  <= dec_legal && mis_raw && !granule_ok;
          state    <= trap_evt ? S_DONE : S_RD_REQ;
        end
        S_RD_REQ:  if (mem_gnt) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid) begin
          cap_old <= cap_word ? {32'b0, mem_rdata[31:0]} : mem_rdata;
          state   <= S_WR_REQ;
        end
        S_WR_REQ:  if (mem_gnt) state <= S_WR_WAIT;
        S_WR_WAIT: if (mem_rvalid) state <= S_DONE;
        S_DONE:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  logic clean_done;
  assign clean_done = done && !cap_mis && !cap_ill;

  assign busy       = (state != S_IDLE);
  assign mem_req    = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign mem_we     = (state == S_WR_REQ);
  assign mem_dword  = !cap_word;
  assign mem_addr   = cap_addr;
  assign mem_wdata  = new_val;
  assign mem_lock   = (state == S_RD_REQ) || (state == S_RD_WAIT) ||
                      (state == S_WR_REQ) || (state == S_WR_WAIT);
  assign acquire    = busy && cap_aq;
  assign release_o  = busy && cap_rl;
  assign done       = (state == S_DONE);
  assign rd_we      = clean_done && (cap_rd != 5'd0);
  assign rd_idx     = cap_rd;
  assign rd_data    = rd_we ? ret_val : 64'b0;
  assign misaligned = done && cap_mis;
  assign op_illegal = done && cap_ill;

  // R2
  lock_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  // R2
  lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !wr_ack_evt) |=> mem_lock);
  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat_evt |=> (mem_req && mem_we));
  // R6
  rd_write_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (done && rd_idx != 5'd0 && !misaligned && !op_illegal));
  // R7
  trap_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> (done && !mem_req && !mem_lock));
  // R5
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_dword) |-> (mem_wdata[63:32] == 32'b0));
  // R9
  sideband_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(acquire) && $stable(release_o)));
  // R10
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(mem_addr) && $stable(rd_idx)));
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       src_val,
  input  logic              granule_ok,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              mem_lock,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              acquire,
  output logic              release_o,
  output logic              done,
  output logic              rd_we,
  output logic [4:0]        rd_idx,
  output logic [63:0]       rd_data,
  output logic              misaligned,
  output logic              op_illegal
);
  amo_kind_e   dec_kind, cap_kind;
  logic        dec_word, dec_aq, dec_rl, dec_legal, cap_word;
  logic [4:0]  dec_rd;
  logic [63:0] cap_src, cap_old, new_val, ret_val;

  amo_rmw_decode u_dec (
    .instr(instr), .kind(dec_kind), .is_word(dec_word), .rd(dec_rd),
    .aq(dec_aq), .rl(dec_rl), .legal(dec_legal)
  );

  amo_rmw_alu u_alu (
    .kind(cap_kind), .is_word(cap_word), .old_val(cap_old),
    .src_val(cap_src), .new_val(new_val), .ret_val(ret_val)
  );

  amo_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .dec_kind(dec_kind), .dec_word(dec_word), .dec_rd(dec_rd),
    .dec_aq(dec_aq), .dec_rl(dec_rl), .dec_legal(dec_legal),
    .addr(addr), .src_val(src_val), .granule_ok(granule_ok),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .new_val(new_val), .ret_val(ret_val),
    .cap_kind(cap_kind), .cap_word(cap_word), .cap_src(cap_src),
    .cap_old(cap_old), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_dword(mem_dword), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_lock(mem_lock), .acquire(acquire), .release_o(release_o),
    .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .misaligned(misaligned), .op_illegal(op_illegal)
  );

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mem_lock && !acquire && !release_o && !rd_we));
endmodule

// File: tb/amo_rmw_unit_bench.sv
module amo_rmw_unit_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   src_val = '0;
  logic          granule_ok = 1'b0;
  logic          mem_gnt = 1'b1;
  logic          mem_rvalid = 1'b0;
  logic [63:0]   mem_rdata = '0;
  logic busy, mem_req, mem_we, mem_dword, mem_lock, acquire, release_o;
  logic done, rd_we, misaligned, op_illegal;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, rd_data;
  logic [4:0]    rd_idx;

  always #2 clk = ~clk;  // 250 MHz

  amo_rmw_unit #(.ADDR_W(AW)) u_amo_rmw_unit (.*);

  int n_tests = 0, n_fail = 0;
  logic [63:0] mem [0:15];
  int rd_beats, wr_beats, lock_gap, sb_bad;
  logic exp_aq, exp_rl;

  // Memory responder: one response per request, one cycle later, at negedge.
  initial begin
    logic pend, pend_we, pend_dw;
    logic [AW-1:0] pend_a;
    logic [63:0] pend_d;
    pend = 1'b0; pend_we = 1'b0; pend_dw = 1'b0; pend_a = '0; pend_d = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        pend = 1'b1; pend_we = mem_we; pend_dw = mem_dword;
        pend_a = mem_addr; pend_d = mem_wdata;
        if (mem_we) wr_beats++; else rd_beats++;
      end else if (pend) begin
        pend = 1'b0;
        mem_rvalid = 1'b1;
        if (pend_we) begin
          if (pend_dw) mem[pend_a[6:3]] = pend_d;
          else if (pend_a[2]) mem[pend_a[6:3]][63:32] = pend_d[31:0];
          else mem[pend_a[6:3]][31:0] = pend_d[31:0];
        end else begin
          if (pend_dw) mem_rdata = mem[pend_a[6:3]];
          else mem_rdata = {32'hDEAD_BEEF,
                            pend_a[2] ? mem[pend_a[6:3]][63:32] : mem[pend_a[6:3]][31:0]};
        end
      end
      if ((rd_beats > 0) && (wr_beats == 0 || pend) && !mem_lock) lock_gap++;
      if (busy && (acquire !== exp_aq || release_o !== exp_rl)) sb_bad++;
      if (!busy && (acquire || release_o)) sb_bad++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] f5, input logic aq,
                                     input logic rl, input logic dw, input logic [4:0] rd);
    return {f5, aq, rl, 5'd7, 5'd6, (dw ? 3'b011 : 3'b010), rd, 7'b0101111};
  endfunction

  // Independent reference: returns value the memory word/dword should hold.
  function automatic logic [63:0] ref_new(input logic [4:0] f5, input logic dw,
                                          input logic [63:0] o, input logic [63:0] s);
    logic [31:0] o3, s3, r3;
    logic [63:0] r;
    o3 = o[31:0]; s3 = s[31:0];
    case (f5)
      5'b00000: begin r = o + s;  r3 = o3 + s3; end
      5'b00001: begin r = s;      r3 = s3;      end
      5'b00100: begin r = o ^ s;  r3 = o3 ^ s3; end
      5'b01000: begin r = o | s;  r3 = o3 | s3; end
      5'b01100: begin r = o & s;  r3 = o3 & s3; end
      5'b10000: begin r = ($signed(o) > $signed(s)) ? s : o;
                      r3 = ($signed(o3) > $signed(s3)) ? s3 : o3; end
      5'b10100: begin r = ($signed(o) > $signed(s)) ? o : s;
                      r3 = ($signed(o3) > $signed(s3)) ? o3 : s3; end
      5'b11000: begin r = (o > s) ? s : o; r3 = (o3 > s3) ? s3 : o3; end
      default:  begin r = (o > s) ? o : s; r3 = (o3 > s3) ? o3 : s3; end
    endcase
    return dw ? r : {32'b0, r3};
  endfunction

  // Launch one request and wait for done; leaves time at the done negedge.
  task automatic run(input logic [31:0] iw, input logic [AW-1:0] a,
                     input logic [63:0] s, input logic g, input logic poke);
    int guard;
    rd_beats = 0; wr_beats = 0; lock_gap = 0; sb_bad = 0;
    exp_aq = iw[26]; exp_rl = iw[25];
    @(negedge clk);
    instr = iw; addr = a; src_val = s; granule_ok = g; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; granule_ok = 1'b0;
    if (poke) begin
      instr = mk(5'b00001, 1'b0, 1'b0, 1'b1, 5'd9);
      addr = 32'h0000_0038; src_val = '1; req_valid = 1'b1;
    end
    guard = 0;
    while (!done && guard < 50) begin @(negedge clk); guard++; end
    req_valid = 1'b0;
  endtask

  initial begin
    logic [4:0] ops [9];
    logic [63:0] pa [4];
    logic [63:0] pb [4];
    logic [63:0] init, expn, old;
    ops = '{5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
            5'b10000, 5'b10100, 5'b11000, 5'b11100};
    pa = '{64'h0000_0000_0000_0005, 64'hFFFF_FFFF_8000_0000,
           64'h7FFF_FFFF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFE};
    pb = '{64'hABCD_0000_0000_0003, 64'h0000_0001_7FFF_FFFF,
           64'h8000_0000_0000_0001, 64'h5555_0000_0000_0002};
    for (int i = 0; i < 16; i++) mem[i] = 64'h0;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 outs", {done, mem_req, mem_lock, rd_we, acquire, release_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R9: sweep all ops, both widths, operand pairs
    for (int o = 0; o < 9; o++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 4; p++) begin
          logic [AW-1:0] a;
          a = (w == 1) ? 32'h10 : ((p % 2 == 1) ? 32'h14 : 32'h10);
          init = {pa[p][31:0] ^ 32'h0F0F_0F0F, pa[p][31:0]};
          if (w == 1) init = pa[p];
          if (w == 0 && a[2]) init = {pa[p][31:0], 32'hCAFE_F00D};
          mem[2] = init;
          old = (w == 1) ? init : {32'b0, (a[2] ? init[63:32] : init[31:0])};
          run(mk(ops[o], o[0], o[1], w[0], 5'd5), a, pb[p], 1'b0, 1'b0);
          chk("R1 R6 done rd_we", {done, rd_we, rd_idx}, {2'b11, 5'd5});
          chk("R5 rd_data", rd_data,
              (w == 1) ? old : {{32{old[31]}}, old[31:0]});
          expn = ref_new(ops[o], w[0], old, pb[p]);
          if (w == 1) chk("R3 R4 mem dword", mem[2], expn);
          else if (a[2]) chk("R3 R4 R5 mem hi word", mem[2], {expn[31:0], init[31:0]});
          else chk("R3 R4 R5 mem lo word", mem[2], {init[63:32], expn[31:0]});
          chk("R2 beats", {rd_beats[3:0], wr_beats[3:0]}, 8'h11);
          chk("R2 R9 lock/sideband", {lock_gap[7:0], sb_bad[7:0]}, 0);
          @(negedge clk);
          chk("R2 lock released", mem_lock, 0);
        end

    // R6 rd = x0: memory updated, no register write
    mem[3] = 64'd40;
    run(mk(5'b00000, 1'b0, 1'b0, 1'b1, 5'd0), 32'h18, 64'd2, 1'b0, 1'b0);
    chk("R6 x0 no rd_we", rd_we, 0);
    chk("R6 x0 mem", mem[3], 64'd42);

    // R7 misaligned, no granule
    mem[4] = 64'h77;
    run(mk(5'b00001, 1'b1, 1'b1, 1'b1, 5'd3), 32'h24, 64'h1, 1'b0, 1'b0);
    chk("R7 flags", {done, misaligned, rd_we}, 3'b110);
    chk("R7 no traffic", rd_beats + wr_beats, 0);
    chk("R7 mem kept", mem[4], 64'h77);
    run(mk(5'b00000, 1'b0, 1'b0, 1'b0, 5'd3), 32'h22, 64'h1, 1'b0, 1'b0);
    chk("R7 word misaligned", {misaligned, rd_we}, 2'b10);

    // R8 granule override
    mem[4] = 64'd100;
    run(mk(5'b00000, 1'b0, 1'b0, 1'b1, 5'd3), 32'h24, 64'd5, 1'b1, 1'b0);
    chk("R8 no exception", {misaligned, rd_we}, 2'b01);
    chk("R8 rd old", rd_data, 64'd100);
    chk("R8 mem", mem[4], 64'd105);

    // R1 illegal encodings
    run(mk(5'b00010, 1'b0, 1'b0, 1'b1, 5'd3), 32'h28, 64'd1, 1'b0, 1'b0);
    chk("R1 bad funct5", {op_illegal, rd_we, misaligned}, 3'b100);
    run({mk(5'b00000, 1'b0, 1'b0, 1'b1, 5'd3)} & ~32'h0000_7000 | 32'h0000_4000,
        32'h28, 64'd1, 1'b0, 1'b0);
    chk("R1 bad width", {op_illegal, rd_we}, 2'b10);
    run(mk(5'b00000, 1'b0, 1'b0, 1'b1, 5'd3) & ~32'h7F, 32'h28, 64'd1, 1'b0, 1'b0);
    chk("R1 bad opcode", op_illegal, 1);
    chk("R1 no traffic", rd_beats + wr_beats, 0);

    // R10 request while busy is ignored
    mem[5] = 64'd10; mem[7] = 64'h99;
    run(mk(5'b00000, 1'b1, 1'b0, 1'b1, 5'd4), 32'h28, 64'd1, 1'b0, 1'b1);
    chk("R10 first op result", {rd_idx, rd_data}, {5'd4, 64'd10});
    chk("R10 mem", mem[5], 64'd11);
    chk("R10 other untouched", mem[7], 64'h99);
    chk("R9 sideband", sb_bad, 0);
    @(negedge clk);
    chk("R10 busy clear", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule